// File: doc/BRIEF.md
# Wired-AND Sequence Slot Synchronizer

This block keeps several power-management controllers in step while they walk through their power-up and power-down slots. All controllers share one open-drain line. Each block pulls the line low while it is still busy with its current slot and lets go once its own work for that slot is done. Because the line is a wired-AND, it reads high only after every controller has let go. Each block moves to the next slot only when it sees that high level, so all devices hold the same slot index at the same time.

The line appears as two pins: a drive-low enable going out, and the combined level coming back in. The block passes the returning level through a two-flop synchronizer before using it. Time is counted in units of an external prescaled tick, and each slot has its own programmed duration. Rail state arrives as one flag per slot:

- rails above the undervoltage threshold
- rails discharged
- discharge enabled

A bypass bit skips the discharge check. If a power-up slot does not finish before its timeout, the block enters a timeout-sync phase. It holds the line low for a fixed number of ticks and then releases it. Once every device has done the same, they all start power-down together.

All pins are plain level control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `slot_sync`

## Requirements
- R1: After reset the phase is initialize (code 0), the slot index is 0 and the line is driven low. In initialize, the line is driven low exactly while `on_req` is low.
- R2: Leaving initialize for power-up (code 1, slot 0) needs `on_req` high and the synchronized combined line high. While another device holds the line low, the block stays in initialize.
- R3: On entering any power-up or power-down slot, the block drives the line low.
- R4: In a power-up slot, the line is released only when both of these hold:
  - at least the slot's programmed number of ticks have elapsed;
  - the slot's `rail_good` bit is high.
- R5: The slot index changes only after the synchronized combined line reads high. Slots run in ascending order 0..NSLOT-1. After the last power-up slot the phase becomes active (code 2) with slot index 0.
- R6: In a power-down slot (code 3) whose `dis_en` bit is set, the release waits past the programmed duration. It ends when any one of these happens:
  - the slot's `rail_dis` bit goes high;
  - `bypass_dis` is set;
  - duration plus TMO_MARGIN ticks have elapsed.
- R7: In a power-down slot whose `dis_en` bit is clear, the release happens as soon as the programmed duration has elapsed.
- R8: If the line has not been seen high by duration plus TMO_MARGIN ticks into a power-up slot, the phase becomes timeout-sync (code 4) and the slot index is kept. In that phase the line is held low for TSYNC_TICKS ticks and then released.
- R9: In timeout-sync, once the combined line reads high, the phase becomes power-down at slot 0. After the last power-down slot the phase returns to initialize at slot 0.
- R10: In active, the line is not driven. When `on_req` falls, the phase becomes power-down at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse that sets the time unit |
| on_req | input | 1 | Power-on request level |
| line_in | input | 1 | Combined level of the shared line (asynchronous) |
| rail_good | input | NSLOT | Per slot: rails have reached the undervoltage threshold |
| rail_dis | input | NSLOT | Per slot: rails discharged below the short-circuit threshold |
| dis_en | input | NSLOT | Per slot: active discharge enabled |
| bypass_dis | input | 1 | Skip the discharge check in power-down |
| slot_dur | input | NSLOT*DUR_W | Slot durations in ticks, slot k at bits [k*DUR_W +: DUR_W] |
| slot_idx | output | SW | Current slot index |
| phase_o | output | 3 | Phase: 0 init, 1 power-up, 2 active, 3 power-down, 4 timeout-sync |
| line_drive_low | output | 1 | Pull the shared line low |

## Verification
The hardest situation to reach is timeout-sync while a peer keeps the line low after this block's release. The bench models the peer device with its own drive-low signal that is combined with the DUT's output. It withholds one slot's `rail_good` until the timeout fires. It then keeps the peer pulling low through the whole hold window, so the release after TSYNC_TICKS can be seen at the pin before the phase moves on. A scoreboard queue holds the expected sequence of phase and slot pairs across two full power cycles, one clean and one faulted.

// File: rtl/slot_sync_pkg.sv
package slot_sync_pkg;
  typedef enum logic [2:0] {
    PH_INIT   = 3'd0,
    PH_PUP    = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_PDN    = 3'd3,
    PH_TSYNC  = 3'd4
  } phase_t;
endpackage

// File: rtl/slot_sync_cdc.sv
module slot_sync_cdc #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/slot_sync_timer.sv
module slot_sync_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  output logic [W-1:0] elapsed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      elapsed <= '0;
    else if (clear)                  elapsed <= '0;
    else if (tick && !(&elapsed))    elapsed <= elapsed + W'(1);
  end
endmodule

// File: rtl/slot_sync.sv
module slot_sync
  import slot_sync_pkg::*;
#(
  parameter int NSLOT       = 8,
  parameter int DUR_W       = 8,
  parameter int TMO_MARGIN  = 64,
  parameter int TSYNC_TICKS = 30,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int EW = DUR_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   on_req,
  input  logic                   line_in,
  input  logic [NSLOT-1:0]       rail_good,
  input  logic [NSLOT-1:0]       rail_dis,
  input  logic [NSLOT-1:0]       dis_en,
  input  logic                   bypass_dis,
  input  logic [NSLOT*DUR_W-1:0] slot_dur,
  output logic [SW-1:0]          slot_idx,
  output logic [2:0]             phase_o,
  output logic                   line_drive_low
);
  phase_t        phase_q, phase_n;
  logic [SW-1:0] slot_q, slot_n;
  logic          rel_q, rel_n;
  logic          seen_q, seen_n;
  logic          clr;
  logic          line_s;
  logic [EW-1:0] elapsed;
  logic [DUR_W-1:0] dur_arr [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_dur
    assign dur_arr[k] = slot_dur[k*DUR_W +: DUR_W];
  end

  slot_sync_cdc #(.STAGES(2)) u_cdc (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  slot_sync_timer #(.W(EW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(clr), .tick(tick), .elapsed(elapsed)
  );

  logic [EW-1:0] dur_x, tmo_x;
  logic          t_done, t_tmo, ts_done, last, step, pup_ok, pdn_ok, dis_clear;

  always_comb begin
    dur_x     = EW'(dur_arr[slot_q]);
    tmo_x     = dur_x + EW'(TMO_MARGIN);
    t_done    = elapsed >= dur_x;
    t_tmo     = elapsed >= tmo_x;
    ts_done   = elapsed >= EW'(TSYNC_TICKS);
    last      = slot_q == SW'(NSLOT - 1);
    step      = rel_q && line_s;
    dis_clear = !dis_en[slot_q] || bypass_dis || rail_dis[slot_q];
    pup_ok    = seen_q && t_done && rail_good[slot_q];
    pdn_ok    = seen_q && (t_tmo || (t_done && dis_clear));
  end

  always_comb begin
    phase_n = phase_q;
    slot_n  = slot_q;
    rel_n   = rel_q;
    seen_n  = seen_q || !line_s;
    clr     = 1'b0;
    unique case (phase_q)
      PH_INIT: if (on_req && line_s) begin
        phase_n = PH_PUP; slot_n = '0; clr = 1'b1;
      end
      PH_PUP: begin
        if (step) begin
          clr = 1'b1;
          if (last) begin phase_n = PH_ACTIVE; slot_n = '0; end
          else      slot_n = slot_q + SW'(1);
        end else if (t_tmo) begin
          phase_n = PH_TSYNC; clr = 1'b1;
        end else if (pup_ok) rel_n = 1'b1;
      end
      PH_ACTIVE: if (!on_req) begin
        phase_n = PH_PDN; slot_n = '0; clr = 1'b1;
      end
      PH_PDN: begin
        if (step) begin
          clr = 1'b1;
          if (last) begin phase_n = PH_INIT; slot_n = '0; end
          else      slot_n = slot_q + SW'(1);
        end else if (pdn_ok) rel_n = 1'b1;
      end
      PH_TSYNC: begin
        if (step) begin
          phase_n = PH_PDN; slot_n = '0; clr = 1'b1;
        end else if (ts_done) rel_n = 1'b1;
      end
      default: begin
        phase_n = PH_INIT; slot_n = '0; clr = 1'b1;
      end
    endcase
    if (clr) begin
      rel_n  = 1'b0;
      seen_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INIT;
      slot_q  <= '0;
      rel_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      slot_q  <= slot_n;
      rel_q   <= rel_n;
      seen_q  <= seen_n;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_INIT:   line_drive_low = !on_req;
      PH_ACTIVE: line_drive_low = 1'b0;
      default:   line_drive_low = !rel_q;
    endcase
  end

  assign slot_idx = slot_q;
  assign phase_o  = phase_q;
endmodule

// File: rtl/slot_sync_chk.sv
module slot_sync_chk #(
  parameter int NSLOT = 8,
  parameter int SW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             on_req,
  input logic             line_s,
  input logic [NSLOT-1:0] rail_good,
  input logic [SW-1:0]    slot_idx,
  input logic [2:0]       phase_o,
  input logic             line_drive_low
);
  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd0 && !on_req) |-> line_drive_low); // R1

  AST_SLOT_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_o == 3'd1 || phase_o == 3'd3) && slot_idx != $past(slot_idx)) |-> line_drive_low); // R3

  AST_PUP_RELEASE_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1 && $past(phase_o) == 3'd1 && $fell(line_drive_low)) |-> $past(rail_good[slot_idx])); // R4

  AST_LINE_GATES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_o == 3'd1 || phase_o == 3'd3) && !line_s) |=> $stable(slot_idx)); // R5

  AST_TSYNC_FROM_PUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_o == 3'd4) |-> $past(phase_o) == 3'd1); // R8

  AST_ACTIVE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd2) |-> !line_drive_low); // R10

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o <= 3'd4); // R5
endmodule

bind slot_sync slot_sync_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .on_req(on_req), .line_s(line_s),
  .rail_good(rail_good), .slot_idx(slot_idx), .phase_o(phase_o),
  .line_drive_low(line_drive_low)
);

// File: tb/slot_sync_tb.sv
module slot_sync_tb;
  localparam int NSLOT = 3, DUR_W = 6, TMO_MARGIN = 8, TSYNC_TICKS = 5;
  localparam int SW = 2;

  logic clk = 0, rst_n = 0, tick = 0, on_req = 0, bypass_dis = 0, peer_low = 0;
  logic [NSLOT-1:0] rail_good = '0, rail_dis = '0, dis_en = '0;
  logic [NSLOT*DUR_W-1:0] slot_dur = {6'd1, 6'd3, 6'd2};
  logic [SW-1:0] slot_idx;
  logic [2:0] phase_o;
  logic line_drive_low, line_in;
  int checks = 0, fails = 0, tcnt = 0;

  always #5 clk = ~clk;
  assign line_in = !(line_drive_low || peer_low);

  always @(posedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 3);
  end

  slot_sync #(.NSLOT(NSLOT), .DUR_W(DUR_W), .TMO_MARGIN(TMO_MARGIN),
              .TSYNC_TICKS(TSYNC_TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .on_req(on_req), .line_in(line_in),
    .rail_good(rail_good), .rail_dis(rail_dis), .dis_en(dis_en),
    .bypass_dis(bypass_dis), .slot_dur(slot_dur), .slot_idx(slot_idx),
    .phase_o(phase_o), .line_drive_low(line_drive_low));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard: expected {phase,slot} transitions
  logic [4:0] exp_q[$];
  logic [4:0] prev_st = 5'd0;

  task automatic push_exp(input int ph, input int sl);
    exp_q.push_back({3'(ph), 2'(sl)});
  endtask

  always @(negedge clk) begin
    if (rst_n && {phase_o, slot_idx} != prev_st) begin
      if (exp_q.size() == 0)
        check(0, "R5 unexpected transition", int'({phase_o, slot_idx}), -1);
      else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        check({phase_o, slot_idx} == e, "R5 phase/slot sequence",
              int'({phase_o, slot_idx}), int'(e));
      end
      prev_st = {phase_o, slot_idx};
    end
  end

  task automatic wait_state(input int ph, input int sl, input int maxc,
                            input string req, output int took);
    took = 0;
    while (!(phase_o == 3'(ph) && slot_idx == 2'(sl)) && took < maxc) begin
      @(negedge clk); took++;
    end
    check(phase_o == 3'(ph) && slot_idx == 2'(sl), req,
          int'({phase_o, slot_idx}), int'({3'(ph), 2'(sl)}));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #1_000_000;
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    check(phase_o == 3'd0 && slot_idx == 0, "R1 reset state", int'(phase_o), 0);
    check(line_drive_low == 1'b1, "R1 init holds line", int'(line_drive_low), 1);

    // first power cycle: clean
    push_exp(1, 0); push_exp(1, 1); push_exp(1, 2); push_exp(2, 0);
    push_exp(3, 0); push_exp(3, 1); push_exp(3, 2); push_exp(0, 0);
    rail_good = 3'b110;
    peer_low = 1;
    on_req = 1;
    idle(20);
    check(line_drive_low == 1'b0, "R1 released after on request", int'(line_drive_low), 0);
    check(phase_o == 3'd0, "R2 waits for peer", int'(phase_o), 0);
    peer_low = 0;
    wait_state(1, 0, 20, "R2 enters power-up", t);
    check(line_drive_low == 1'b1, "R3 slot0 entry low", int'(line_drive_low), 1);
    idle(20);
    check(line_drive_low == 1'b1, "R4 holds without rail_good", int'(line_drive_low), 1);
    rail_good[0] = 1'b1;
    wait_state(1, 1, 20, "R4 release advances", t);
    check(line_drive_low == 1'b1, "R3 slot1 entry low", int'(line_drive_low), 1);
    peer_low = 1;
    idle(30);
    check(slot_idx == 2'd1 && line_drive_low == 1'b0, "R5 held by peer",
          int'(slot_idx), 1);
    peer_low = 0;
    wait_state(1, 2, 10, "R5 advance on line high", t);
    wait_state(2, 0, 40, "R5 last slot goes active", t);
    idle(5);
    check(line_drive_low == 1'b0, "R10 active not driving", int'(line_drive_low), 0);
    dis_en = 3'b011;
    on_req = 0;
    wait_state(3, 0, 10, "R10 off request to power-down", t);
    idle(20);
    check(line_drive_low == 1'b1, "R6 discharge extends slot", int'(line_drive_low), 1);
    rail_dis[0] = 1'b1;
    bypass_dis = 1'b1;
    wait_state(3, 1, 15, "R6 discharged releases", t);
    wait_state(3, 2, 80, "R6 bypass ends slot", t);
    check(t <= 25, "R6 bypass before timeout", t, 25);
    wait_state(0, 0, 80, "R9 last power-down to init", t);
    check(t <= 16, "R7 duration-only slot", t, 16);
    check(line_drive_low == 1'b1, "R1 init holds line again", int'(line_drive_low), 1);

    // second power cycle: slot 1 rails never good
    push_exp(1, 0); push_exp(1, 1); push_exp(4, 1);
    push_exp(3, 0); push_exp(3, 1); push_exp(3, 2); push_exp(0, 0);
    rail_good = 3'b101;
    rail_dis = '0;
    bypass_dis = 0;
    on_req = 1;
    wait_state(1, 0, 20, "R2 second power-up", t);
    wait_state(1, 1, 60, "R4 slot0 again", t);
    wait_state(4, 1, 100, "R8 timeout to sync", t);
    check(t >= 36, "R8 not before timeout", t, 36);
    peer_low = 1;
    on_req = 0;
    idle(8);
    check(line_drive_low == 1'b1, "R8 sync hold low", int'(line_drive_low), 1);
    idle(40);
    check(line_drive_low == 1'b0 && phase_o == 3'd4, "R8 sync release",
          int'(line_drive_low), 0);
    peer_low = 0;
    wait_state(3, 0, 10, "R9 sync to power-down", t);
    idle(20);
    check(line_drive_low == 1'b1, "R6 no discharge yet", int'(line_drive_low), 1);
    wait_state(3, 1, 80, "R6 timeout ends extension", t);
    wait_state(3, 2, 100, "R6 timeout slot1", t);
    wait_state(0, 0, 40, "R9 back to init", t);
    idle(5);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule